// File: doc/BRIEF.md
# Burst-Gated Shadow Register Update

This block is the register side of a timer that reloads its timing registers by burst DMA. It holds three register pairs: period, compare 1 and compare 3. Each pair has a shadow copy and an active copy. A compare-1 event asks for a DMA burst. The DMA controller then writes three words to one data address. The block counts the words and steers each one into the right shadow register.

When the active copies change depends on the preload enable, a 4-bit gating code and a repetition-update enable. With preload off, each word goes straight through to its active register. With preload on, all three active registers change together. This happens either at the end of the burst or at a later repetition event, so the counter never runs with a mix of old and new settings.

The DMA controller and the counter are outside the block. The block sees the write strobe, the compare-1 event and the repetition event as single-cycle inputs.

Top module: `burst_shadow_update`

## Requirements
- R1: After a synchronous reset, the DMA request is low and the period, compare-1 and compare-3 outputs are all zero. No burst is in progress and no transfer is pending.
- R2: A compare-1 event sampled while no burst is in progress raises the DMA request at the next clock edge. The request stays high until the edge that accepts the first burst write, and is low after that edge.
- R3: A compare-1 event sampled during a burst has no effect. A write strobe sampled while no burst is in progress is discarded and changes no register.
- R4: The three accepted writes of a burst fill the shadow registers in a fixed order: word 0 goes to period, word 1 to compare 1 and word 2 to compare 3. The burst ends with the third write.
- R5: With preload disabled, each active register takes its burst word at the same clock edge that accepts that word.
- R6: With preload enabled and gating code 4'b0001, all three active registers load their shadow values together. This happens at the clock edge one cycle after the edge that accepted the last word of the burst.
- R7: With preload enabled, gating code 4'b0010 and repetition-update enabled, the completed burst stays pending. All three active registers load from shadow at the edge that samples the first repetition event after the burst has ended.
- R8: With preload enabled, gating code 4'b0010 and repetition-update disabled, a completed burst stays pending and the active registers do not change.
- R9: With preload enabled and any gating code other than 4'b0001 and 4'b0010, the active registers load from shadow at every repetition event sampled while no burst is in progress, whether or not a burst is pending.
- R10: No shadow-to-active transfer takes place while a burst is in progress. A transfer clears the pending burst, so gating code 4'b0010 transfers once per burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Write strobe to the burst data address |
| bus_wr_data | input | DATA_W | Write data for the burst data address |
| cmp1_evt | input | 1 | Compare-1 match event, one cycle wide |
| rep_evt | input | 1 | Counter repetition event, one cycle wide |
| preload_en | input | 1 | 1 = writes go through the shadows; 0 = writes go straight to the active registers |
| gate_code | input | 4 | Update-gating selector |
| rep_upd_en | input | 1 | Allows the repetition event to trigger the transfer under code 4'b0010 |
| dma_req | output | 1 | DMA burst request |
| period_q | output | DATA_W | Active period value |
| cmp1_q | output | DATA_W | Active compare-1 value |
| cmp3_q | output | DATA_W | Active compare-3 value |

## Verification
The bench uses the default DATA_W of 16. It draws random words across the full 16-bit range, so a word that lands in the wrong slot or a stale active value shows up at once. Random stimulus switches among gating codes 4'b0001 and 4'b0010, with and without the repetition-update enable, and a spread of fallback codes. It mixes preload on and off. This covers repetition events that arrive during a burst, compare-1 events that arrive during a burst, and writes that arrive between bursts. Directed sequences pin down the exact edge on which each gating mode makes the active registers change.

// File: rtl/burst_upd_pkg.sv
package burst_upd_pkg;

    localparam int SLOT_CNT = 3;
    localparam int IDX_W    = $clog2(SLOT_CNT);
    localparam int GATE_W   = 4;

    // Slot order follows the burst word order
    typedef enum logic [IDX_W-1:0] {
        SLOT_PERIOD = 0,
        SLOT_CMP1   = 1,
        SLOT_CMP3   = 2
    } slot_e;

    typedef enum logic [1:0] {
        GM_BURST_END = 2'd0,
        GM_NEXT_REP  = 2'd1,
        GM_HOLD      = 2'd2,
        GM_EVERY_REP = 2'd3
    } gate_mode_e;

    localparam logic [GATE_W-1:0] CODE_BURST_END = 4'b0001;
    localparam logic [GATE_W-1:0] CODE_BURST_REP = 4'b0010;

    typedef struct packed {
        logic             busy;
        logic             req;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    function automatic gate_mode_e decode_gate(input logic [GATE_W-1:0] code,
                                               input logic rep_en);
        gate_mode_e m;
        if (code == CODE_BURST_END)
            m = GM_BURST_END;
        else if (code == CODE_BURST_REP)
            m = rep_en ? GM_NEXT_REP : GM_HOLD;
        else
            m = GM_EVERY_REP;
        return m;
    endfunction

endpackage

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp1_evt,
    input  logic             wr_en,
    output logic             dma_req,
    output logic             busy,
    output logic             wr_acc,
    output logic [IDX_W-1:0] wr_idx,
    output logic             burst_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_CNT - 1);

    seq_state_t st_q, st_d;

    assign busy       = st_q.busy;
    assign dma_req    = st_q.req;
    assign wr_idx     = st_q.idx;
    assign wr_acc     = wr_en && st_q.busy;
    assign burst_done = wr_acc && (st_q.idx == LAST_IDX);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (cmp1_evt) begin
                st_d.busy = 1'b1;
                st_d.req  = 1'b1;
                st_d.idx  = '0;
            end
        end else if (wr_acc) begin
            st_d.req = 1'b0;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !dma_req);

    // R3
    cmp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp1_evt && !wr_en) |=> (busy && $stable(wr_idx) && $stable(dma_req)));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_idx <= LAST_IDX);

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import burst_upd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_acc,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [SLOT_CNT-1:0][DATA_W-1:0]  shadow_q
);
    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[s] <= '0;
            else if (wr_acc && wr_idx == IDX_W'(s))
                shadow_q[s] <= wr_data;
        end
    end
endmodule

// File: rtl/update_ctrl.sv
module update_ctrl
    import burst_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_done,
    input  logic              busy,
    input  logic              rep_evt,
    input  logic              preload_en,
    input  logic [GATE_W-1:0] gate_code,
    input  logic              rep_upd_en,
    output logic              transfer,
    output logic              pending
);
    gate_mode_e mode;
    logic       mode_fire;

    assign mode = decode_gate(gate_code, rep_upd_en);

    always_comb begin
        unique case (mode)
            GM_BURST_END: mode_fire = pending;
            GM_NEXT_REP:  mode_fire = pending && rep_evt;
            GM_HOLD:      mode_fire = 1'b0;
            GM_EVERY_REP: mode_fire = rep_evt;
            default:      mode_fire = 1'b0;
        endcase
    end

    assign transfer = preload_en && !busy && mode_fire;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (burst_done && preload_en)
            pending <= 1'b1;
        else if (transfer)
            pending <= 1'b0;
    end

    // R10
    no_mix_chk: assert property (@(posedge clk) disable iff (rst)
        transfer |-> !busy);

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        transfer |=> !pending);

    // R6
    end_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_done && preload_en) |=> pending);

endmodule

// File: rtl/active_bank.sv
module active_bank
    import burst_upd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             preload_en,
    input  logic                             wr_acc,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             transfer,
    input  logic [SLOT_CNT-1:0][DATA_W-1:0]  shadow_q,
    output logic [SLOT_CNT-1:0][DATA_W-1:0]  active_q
);
    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                active_q[s] <= '0;
            else if (!preload_en && wr_acc && wr_idx == IDX_W'(s))
                active_q[s] <= wr_data;
            else if (transfer)
                active_q[s] <= shadow_q[s];
        end

        // R6
        copy_chk: assert property (@(posedge clk) disable iff (rst)
            transfer |=> (active_q[s] == $past(shadow_q[s])));
    end
endmodule

// File: rtl/burst_shadow_update.sv
module burst_shadow_update
    import burst_upd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              cmp1_evt,
    input  logic              rep_evt,
    input  logic              preload_en,
    input  logic [3:0]        gate_code,
    input  logic              rep_upd_en,
    output logic              dma_req,
    output logic [DATA_W-1:0] period_q,
    output logic [DATA_W-1:0] cmp1_q,
    output logic [DATA_W-1:0] cmp3_q
);
    logic                            busy;
    logic                            wr_acc;
    logic [IDX_W-1:0]                wr_idx;
    logic                            burst_done;
    logic                            transfer;
    logic                            pending;
    logic [SLOT_CNT-1:0][DATA_W-1:0] shadow_q;
    logic [SLOT_CNT-1:0][DATA_W-1:0] active_q;

    burst_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmp1_evt   (cmp1_evt),
        .wr_en      (bus_wr_en),
        .dma_req    (dma_req),
        .busy       (busy),
        .wr_acc     (wr_acc),
        .wr_idx     (wr_idx),
        .burst_done (burst_done)
    );

    shadow_bank #(.DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_acc   (wr_acc),
        .wr_idx   (wr_idx),
        .wr_data  (bus_wr_data),
        .shadow_q (shadow_q)
    );

    update_ctrl u_upd (
        .clk        (clk),
        .rst        (rst),
        .burst_done (burst_done),
        .busy       (busy),
        .rep_evt    (rep_evt),
        .preload_en (preload_en),
        .gate_code  (gate_code),
        .rep_upd_en (rep_upd_en),
        .transfer   (transfer),
        .pending    (pending)
    );

    active_bank #(.DATA_W(DATA_W)) u_active (
        .clk        (clk),
        .rst        (rst),
        .preload_en (preload_en),
        .wr_acc     (wr_acc),
        .wr_idx     (wr_idx),
        .wr_data    (bus_wr_data),
        .transfer   (transfer),
        .shadow_q   (shadow_q),
        .active_q   (active_q)
    );

    assign period_q = active_q[SLOT_PERIOD];
    assign cmp1_q   = active_q[SLOT_CMP1];
    assign cmp3_q   = active_q[SLOT_CMP3];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!dma_req && period_q == '0 && cmp1_q == '0 && cmp3_q == '0));

    // R5
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && wr_acc && wr_idx == IDX_W'(SLOT_PERIOD)) |=> (period_q == $past(bus_wr_data)));

endmodule

// File: tb/test_burst_shadow_update.sv
`timescale 1ns/1ps
module test_burst_shadow_update;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr_en;
    logic [DW-1:0] bus_wr_data;
    logic          cmp1_evt;
    logic          rep_evt;
    logic          preload_en;
    logic [3:0]    gate_code;
    logic          rep_upd_en;
    logic          dma_req;
    logic [DW-1:0] period_q, cmp1_q, cmp3_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit          m_busy, m_req, m_pend;
    int          m_idx;
    logic [DW-1:0] m_sh [3];
    logic [DW-1:0] m_act[3];

    always #10 clk = ~clk;

    burst_shadow_update #(.DATA_W(DW)) i_burst_shadow_update (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .cmp1_evt(cmp1_evt), .rep_evt(rep_evt), .preload_en(preload_en),
        .gate_code(gate_code), .rep_upd_en(rep_upd_en), .dma_req(dma_req),
        .period_q(period_q), .cmp1_q(cmp1_q), .cmp3_q(cmp3_q)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag();
        if (!preload_en)         return "R5";
        if (gate_code == 4'b0001) return "R6";
        if (gate_code == 4'b0010) return rep_upd_en ? "R7" : "R8";
        return "R9";
    endfunction

    function automatic bit model_transfer();
        if (!preload_en || m_busy) return 0;
        if (gate_code == 4'b0001) return m_pend;
        if (gate_code == 4'b0010) return rep_upd_en ? (m_pend && rep_evt) : 0;
        return rep_evt;
    endfunction

    // one clock edge of the reference, from the sampled inputs
    task automatic model_step();
        bit acc, last, tr;
        acc  = bus_wr_en && m_busy;
        last = acc && (m_idx == 2);
        tr   = model_transfer();
        for (int k = 0; k < 3; k++) begin
            if (!preload_en && acc && m_idx == k) m_act[k] = bus_wr_data;
            else if (tr)                          m_act[k] = m_sh[k];
        end
        if (acc) m_sh[m_idx] = bus_wr_data;
        if (last && preload_en) m_pend = 1;
        else if (tr)            m_pend = 0;
        if (!m_busy) begin
            if (cmp1_evt) begin m_busy = 1; m_req = 1; m_idx = 0; end
        end else if (acc) begin
            m_req = 0;
            if (last) begin m_busy = 0; m_idx = 0; end
            else m_idx++;
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_req = 0; m_pend = 0; m_idx = 0;
        for (int k = 0; k < 3; k++) begin m_sh[k] = '0; m_act[k] = '0; end
    endtask

    task automatic compare_all();
        check("R2 dma_req", {{(DW-1){1'b0}}, dma_req}, {{(DW-1){1'b0}}, m_req});
        check({mode_tag(), " period"}, period_q, m_act[0]);
        check({mode_tag(), " cmp1"},   cmp1_q,   m_act[1]);
        check({mode_tag(), " cmp3"},   cmp3_q,   m_act[2]);
    endtask

    // inputs set at a falling edge, one rising edge, compared at the next falling edge
    task automatic tick(input bit wr, input logic [DW-1:0] d, input bit c1, input bit rp);
        bus_wr_en = wr; bus_wr_data = d; cmp1_evt = c1; rep_evt = rp;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, '0, 0, 0);
    endtask

    task automatic set_mode(input bit pre, input logic [3:0] g, input bit re);
        preload_en = pre; gate_code = g; rep_upd_en = re;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1; bus_wr_en = 0; bus_wr_data = '0; cmp1_evt = 0; rep_evt = 0;
        set_mode(0, 4'b0001, 0);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 dma_req", {{(DW-1){1'b0}}, dma_req}, '0);
        check("R1 period", period_q, '0);
        check("R1 cmp1",   cmp1_q,   '0);
        check("R1 cmp3",   cmp3_q,   '0);

        // R3 write between bursts is discarded
        tick(1, 16'hDEAD, 0, 0);
        check("R3 idle write", period_q, '0);

        // R2 request, R4 order, R5 direct writes, R3 cmp1 during burst
        tick(0, '0, 1, 0);
        check("R2 req raised", {{(DW-1){1'b0}}, dma_req}, 16'd1);
        idle(2);
        check("R2 req held", {{(DW-1){1'b0}}, dma_req}, 16'd1);
        tick(1, 16'h1111, 0, 0);
        check("R2 req dropped", {{(DW-1){1'b0}}, dma_req}, '0);
        check("R5 period direct", period_q, 16'h1111);
        tick(0, '0, 1, 0);
        check("R3 cmp1 in burst", {{(DW-1){1'b0}}, dma_req}, '0);
        tick(1, 16'h2222, 0, 0);
        check("R4 cmp1 slot", cmp1_q, 16'h2222);
        tick(1, 16'h3333, 0, 0);
        check("R4 cmp3 slot", cmp3_q, 16'h3333);

        // R6 end-of-burst update
        set_mode(1, 4'b0001, 0);
        tick(0, '0, 1, 0);
        tick(1, 16'hA001, 0, 0);
        tick(1, 16'hA002, 0, 0);
        tick(1, 16'hA003, 0, 0);
        check("R6 not yet", period_q, 16'h1111);
        tick(0, '0, 0, 0);
        check("R6 period", period_q, 16'hA001);
        check("R6 cmp3",   cmp3_q,   16'hA003);

        // R7 next repetition event, R10 no transfer during burst
        set_mode(1, 4'b0010, 1);
        tick(0, '0, 1, 0);
        tick(1, 16'hB001, 0, 1);
        tick(1, 16'hB002, 0, 1);
        tick(1, 16'hB003, 0, 1);
        check("R10 rep in burst", cmp1_q, 16'hA002);
        idle(3);
        check("R7 waits", cmp1_q, 16'hA002);
        tick(0, '0, 0, 1);
        check("R7 period", period_q, 16'hB001);
        check("R7 cmp1",   cmp1_q,   16'hB002);

        // R8 hold with repetition update disabled
        set_mode(1, 4'b0010, 0);
        tick(0, '0, 1, 0);
        tick(1, 16'hC001, 0, 0);
        tick(1, 16'hC002, 0, 0);
        tick(1, 16'hC003, 0, 0);
        tick(0, '0, 0, 1);
        idle(2);
        check("R8 held", cmp3_q, 16'hB003);
        // R10 pending survives; enabling repetition update releases it once
        set_mode(1, 4'b0010, 1);
        tick(0, '0, 0, 1);
        check("R10 released", cmp3_q, 16'hC003);

        // R9 fallback code: every repetition event, none during a burst
        set_mode(1, 4'b0101, 0);
        tick(0, '0, 1, 0);
        tick(1, 16'hD001, 0, 0);
        tick(0, '0, 0, 1);
        check("R10 fallback in burst", period_q, 16'hC001);
        tick(1, 16'hD002, 0, 0);
        tick(1, 16'hD003, 0, 0);
        tick(0, '0, 0, 1);
        check("R9 period", period_q, 16'hD001);
        check("R9 cmp3",   cmp3_q,   16'hD003);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                int sel;
                sel = $urandom_range(0, 3);
                set_mode(($urandom_range(0, 3) != 0),
                         sel == 0 ? 4'b0001 : sel == 1 ? 4'b0010 : 4'($urandom_range(0, 15)),
                         $urandom_range(0, 1) == 1);
            end
            tick($urandom_range(0, 1) == 1, DW'($urandom),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule